// File: doc/BRIEF.md
# Lowest-priority interrupt redirection router

This block picks a single destination CPU for every interrupt request it receives. Each interrupt source owns a routing entry, which is a CPU mask plus a redirectable flag. Only the lowest-numbered set bit of the mask counts. That bit names the entry's default CPU.

A fixed entry always goes to its default CPU. A redirectable entry goes to the CPU whose task-priority hint is smallest. The search walks the CPUs in circular order and starts at the default CPU.

Software-side logic writes the per-CPU hints and the routing entries through two simple write ports. A request is registered first. The destination is then chosen combinationally and driven out as a registered one-hot vector together with a single-cycle delivery strobe. A build-time parameter turns off redirection for platforms that lack it. In that case every entry is fixed, and the reset targets are spread round-robin over the CPUs.

Top module: `irq_redir_router`

## Requirements
- R1: `deliver_o` pulses for exactly one cycle per request. While it is high, `dest_o` has exactly one bit set. While it is low, `dest_o` is all zero.
- R2: A fixed entry (redirectable flag 0) is delivered to the CPU of the lowest set bit of its mask. All higher mask bits are ignored.
- R3: An entry whose mask is all zero uses CPU 0 as its default CPU.
- R4: A redirectable entry (flag 1) goes to the CPU with the smallest hint value. Ties go to the first CPU reached when stepping upward from the default CPU, wrapping from NUM_CPUS-1 to 0. If all hints are equal, the default CPU is chosen.
- R5: Hints are 2 bits: 00 minimal, 01 normal, 10 maximal. A write of 11 is stored and compared as 10. A hint write changes only the addressed CPU's hint.
- R6: After reset, all outputs are zero and every hint is 00. With REDIR_SUPPORT=1, every entry has mask 1 (CPU 0) and the redirectable flag set.
- R7: With REDIR_SUPPORT=0, entry s resets to a fixed route to CPU s mod NUM_CPUS. The redirectable flag of a written entry is forced to 0.
- R8: A request sampled on clock edge k is delivered on edge k+2. The choice uses the entry and hint state present after edge k, including any writes sampled on that same edge. Requests on consecutive cycles are each delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hint_we_i | input | 1 | Hint write enable |
| hint_cpu_i | input | $clog2(NUM_CPUS) | CPU whose hint is written |
| hint_val_i | input | 2 | Hint value (00 min, 01 normal, 10/11 max) |
| entry_we_i | input | 1 | Routing entry write enable |
| entry_src_i | input | $clog2(NUM_SRCS) | Source whose entry is written |
| entry_mask_i | input | NUM_CPUS | New CPU mask |
| entry_redir_i | input | 1 | New redirectable flag |
| req_valid_i | input | 1 | Interrupt request strobe |
| req_src_i | input | $clog2(NUM_SRCS) | Requesting source |
| dest_o | output | NUM_CPUS | One-hot destination CPU |
| deliver_o | output | 1 | Delivery strobe |

## Verification
The hardest case to reach is a redirectable request where the minimum hint is shared by several CPUs on both sides of the default CPU. Only the wrap-around order then decides the winner. A directed step covers it: the default CPU is set near the top of the range, and equal minima are placed below it and past the wrap point. A randomized phase then writes hints (including the 11 code), writes entries and issues requests, all in the same cycles. This exercises the same-edge visibility rule. A second instance built without redirection runs alongside the first to cover the round-robin reset targets and the forced-fixed flag.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  typedef enum logic [1:0] {
    HINT_MIN  = 2'b00,
    HINT_NORM = 2'b01,
    HINT_MAX  = 2'b10
  } hint_e;

  function automatic logic [1:0] hint_clamp(input logic [1:0] v);
    return (v == 2'b11) ? 2'(HINT_MAX) : v;
  endfunction
endpackage

// File: rtl/irq_hint_regs.sv
module irq_hint_regs #(
  parameter int NUM_CPUS = 8,
  localparam int CW = $clog2(NUM_CPUS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] cpu_i,
  input  logic [1:0]    val_i,
  output logic [1:0]    hint_o [NUM_CPUS]
);
  import irq_redir_pkg::*;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          hint_o[c] <= 2'(HINT_MIN);
      else if (we_i && cpu_i == CW'(c))     hint_o[c] <= hint_clamp(val_i);
    end

    assert_reserved_is_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && cpu_i == CW'(c) && val_i == 2'b11) |=> hint_o[c] == 2'(HINT_MAX));
    assert_untouched_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && cpu_i == CW'(c)) |=> $stable(hint_o[c]));
  end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table #(
  parameter int NUM_CPUS      = 8,
  parameter int NUM_SRCS      = 16,
  parameter bit REDIR_SUPPORT = 1'b1,
  localparam int SW = $clog2(NUM_SRCS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SW-1:0]       src_i,
  input  logic [NUM_CPUS-1:0] mask_i,
  input  logic                redir_i,
  input  logic [SW-1:0]       rd_src_i,
  output logic [NUM_CPUS-1:0] rd_mask_o,
  output logic                rd_redir_o
);
  logic [NUM_CPUS-1:0] mask_q  [NUM_SRCS];
  logic                redir_q [NUM_SRCS];

  for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
    localparam logic [NUM_CPUS-1:0] RST_MASK =
      REDIR_SUPPORT ? NUM_CPUS'(1) : (NUM_CPUS'(1) << (s % NUM_CPUS));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[s]  <= RST_MASK;
        redir_q[s] <= REDIR_SUPPORT;
      end else if (we_i && src_i == SW'(s)) begin
        mask_q[s]  <= mask_i;
        redir_q[s] <= REDIR_SUPPORT ? redir_i : 1'b0;
      end
    end
  end

  assign rd_mask_o  = mask_q[rd_src_i];
  assign rd_redir_o = redir_q[rd_src_i];
endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel #(
  parameter int NUM_CPUS = 8,
  localparam int CW = $clog2(NUM_CPUS)
) (
  input  logic [NUM_CPUS-1:0] mask_i,
  input  logic                redir_i,
  input  logic [1:0]          hint_i [NUM_CPUS],
  output logic [CW-1:0]       sel_o
);
  logic [CW-1:0] dflt, best;
  logic          found;
  int            j;

  always_comb begin
    dflt  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CPUS; i++) begin
      if (!found && mask_i[i]) begin
        dflt  = CW'(i);
        found = 1'b1;
      end
    end
    // circular walk from the default CPU; strict compare keeps the earliest tie
    best = dflt;
    j    = 0;
    for (int k = 1; k < NUM_CPUS; k++) begin
      j = int'(dflt) + k;
      if (j >= NUM_CPUS) j = j - NUM_CPUS;
      if (hint_i[j] < hint_i[best]) best = CW'(j);
    end
    sel_o = redir_i ? best : dflt;
  end
endmodule

// File: rtl/irq_redir_router.sv
module irq_redir_router #(
  parameter int NUM_CPUS      = 8,
  parameter int NUM_SRCS      = 16,
  parameter bit REDIR_SUPPORT = 1'b1,
  localparam int CW = $clog2(NUM_CPUS),
  localparam int SW = $clog2(NUM_SRCS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hint_we_i,
  input  logic [CW-1:0]       hint_cpu_i,
  input  logic [1:0]          hint_val_i,
  input  logic                entry_we_i,
  input  logic [SW-1:0]       entry_src_i,
  input  logic [NUM_CPUS-1:0] entry_mask_i,
  input  logic                entry_redir_i,
  input  logic                req_valid_i,
  input  logic [SW-1:0]       req_src_i,
  output logic [NUM_CPUS-1:0] dest_o,
  output logic                deliver_o
);
  logic                req_vld_q;
  logic [SW-1:0]       req_src_q;
  logic [1:0]          hint_q [NUM_CPUS];
  logic [NUM_CPUS-1:0] rd_mask;
  logic                rd_redir;
  logic [CW-1:0]       sel;

  irq_hint_regs #(.NUM_CPUS(NUM_CPUS)) u_hint (
    .clk_i, .rst_ni,
    .we_i(hint_we_i), .cpu_i(hint_cpu_i), .val_i(hint_val_i),
    .hint_o(hint_q)
  );

  irq_route_table #(.NUM_CPUS(NUM_CPUS), .NUM_SRCS(NUM_SRCS), .REDIR_SUPPORT(REDIR_SUPPORT)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(entry_we_i), .src_i(entry_src_i), .mask_i(entry_mask_i), .redir_i(entry_redir_i),
    .rd_src_i(req_src_q), .rd_mask_o(rd_mask), .rd_redir_o(rd_redir)
  );

  irq_target_sel #(.NUM_CPUS(NUM_CPUS)) u_sel (
    .mask_i(rd_mask), .redir_i(rd_redir), .hint_i(hint_q), .sel_o(sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_vld_q <= 1'b0;
      req_src_q <= '0;
      deliver_o <= 1'b0;
      dest_o    <= '0;
    end else begin
      req_vld_q <= req_valid_i;
      req_src_q <= req_src_i;
      deliver_o <= req_vld_q;
      dest_o    <= req_vld_q ? (NUM_CPUS'(1) << sel) : '0;
    end
  end

  assert_dest_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_o |-> $countones(dest_o) == 1);
  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deliver_o |-> dest_o == '0);
  assert_fixed_in_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_q && !rd_redir && rd_mask != '0) |=> (dest_o & $past(rd_mask)) == dest_o);
  assert_zero_mask_cpu0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_q && !rd_redir && rd_mask == '0) |=> dest_o[0]);
  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ##2 deliver_o);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_min_chk
    for (genvar o = 0; o < NUM_CPUS; o++) begin : g_other
      assert_picks_minimum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_q && rd_redir) |=> !(dest_o[c] && ($past(hint_q[o]) < $past(hint_q[c]))));
    end
  end
endmodule

// File: tb/irq_redir_router_tb_top.sv
module irq_redir_router_tb_top;
  localparam int N  = 8;
  localparam int S  = 16;
  localparam int CW = $clog2(N);
  localparam int SW = $clog2(S);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          hint_we = 0;
  logic [CW-1:0] hint_cpu = '0;
  logic [1:0]    hint_val = '0;
  logic          entry_we = 0;
  logic [SW-1:0] entry_src = '0;
  logic [N-1:0]  entry_mask = '0;
  logic          entry_redir = 0;
  logic          req_valid = 0;
  logic [SW-1:0] req_src = '0;
  logic [N-1:0]  dest_a, dest_b;
  logic          del_a, del_b;

  irq_redir_router #(.NUM_CPUS(N), .NUM_SRCS(S), .REDIR_SUPPORT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .hint_we_i(hint_we), .hint_cpu_i(hint_cpu), .hint_val_i(hint_val),
    .entry_we_i(entry_we), .entry_src_i(entry_src), .entry_mask_i(entry_mask), .entry_redir_i(entry_redir),
    .req_valid_i(req_valid), .req_src_i(req_src), .dest_o(dest_a), .deliver_o(del_a));

  irq_redir_router #(.NUM_CPUS(N), .NUM_SRCS(S), .REDIR_SUPPORT(1'b0)) dut_fixed_i (
    .clk_i(clk), .rst_ni(rst_n),
    .hint_we_i(hint_we), .hint_cpu_i(hint_cpu), .hint_val_i(hint_val),
    .entry_we_i(entry_we), .entry_src_i(entry_src), .entry_mask_i(entry_mask), .entry_redir_i(entry_redir),
    .req_valid_i(req_valid), .req_src_i(req_src), .dest_o(dest_b), .deliver_o(del_b));

  // behavioural reference model; index 0 = redirect-capable, 1 = fixed-only
  int m_mask  [2][S];
  int m_redir [2][S];
  int m_hint  [N];
  int p_vld, p_src;
  int exp_dest [2];
  int exp_del;
  int vectors = 0, miscompares = 0;
  string cur_req = "R6";
  bit done = 0;

  function automatic int pick(int inst, int src);
    int d = 0, best, c;
    for (int i = N - 1; i >= 0; i--) if (m_mask[inst][src][i]) d = i;
    if (!m_redir[inst][src]) return d;
    best = d;
    for (int k = 1; k < N; k++) begin
      c = (d + k) % N;
      if (m_hint[c] < m_hint[best]) best = c;
    end
    return best;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < S; s++) begin
      m_mask[0][s] = 1;               m_redir[0][s] = 1;
      m_mask[1][s] = 1 << (s % N);    m_redir[1][s] = 0;
    end
    for (int c = 0; c < N; c++) m_hint[c] = 0;
    p_vld = 0; p_src = 0; exp_del = 0; exp_dest[0] = 0; exp_dest[1] = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      for (int i = 0; i < 2; i++) exp_dest[i] = p_vld ? (1 << pick(i, p_src)) : 0;
      exp_del = p_vld;
      if (hint_we) m_hint[hint_cpu] = (hint_val == 2'b11) ? 2 : int'(hint_val);
      if (entry_we) begin
        m_mask[0][entry_src] = int'(entry_mask);  m_redir[0][entry_src] = int'(entry_redir);
        m_mask[1][entry_src] = int'(entry_mask);  m_redir[1][entry_src] = 0;
      end
      p_vld = int'(req_valid);
      p_src = int'(req_src);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (int'(dest_a) != exp_dest[0] || int'(del_a) != exp_del) begin
        miscompares++;
        $display("FAIL %s redir inst: dest=%0h del=%0d expected dest=%0h del=%0d",
                 cur_req, dest_a, del_a, exp_dest[0], exp_del);
      end
      vectors++;
      if (int'(dest_b) != exp_dest[1] || int'(del_b) != exp_del) begin
        miscompares++;
        $display("FAIL %s fixed inst: dest=%0h del=%0d expected dest=%0h del=%0d",
                 cur_req, dest_b, del_b, exp_dest[1], exp_del);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      hint_we = 0; entry_we = 0; req_valid = 0;
    end
  endtask

  task automatic set_hint(int c, int v);
    @(negedge clk);
    entry_we = 0; req_valid = 0;
    hint_we = 1; hint_cpu = CW'(c); hint_val = 2'(v);
  endtask

  task automatic set_entry(int s, int m, bit r);
    @(negedge clk);
    hint_we = 0; req_valid = 0;
    entry_we = 1; entry_src = SW'(s); entry_mask = N'(m); entry_redir = r;
  endtask

  task automatic request(int s);
    @(negedge clk);
    hint_we = 0; entry_we = 0;
    req_valid = 1; req_src = SW'(s);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    // R6 reset state, R7 round-robin reset targets
    cur_req = "R6";
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(2);
    cur_req = "R7";
    for (int s = 0; s < S; s++) request(s);   // also back-to-back, R8
    idle(3);

    // R5 hint encoding, 11 treated as maximal
    cur_req = "R5";
    for (int c = 0; c < N; c++) set_hint(c, 1);
    set_hint(0, 3);
    set_hint(4, 0);
    request(0);                               // default 0 max -> cpu4
    set_hint(4, 3);
    set_hint(2, 2);
    request(0);                               // 0,2,4 at max; others normal -> cpu1
    idle(3);

    // R2 fixed lowest set bit, higher bits ignored; R7 flag forced fixed
    cur_req = "R2";
    set_entry(3, 8'hA8, 1'b0);
    request(3);                               // cpu3
    set_entry(5, 8'h81, 1'b0);
    request(5);                               // cpu0
    set_entry(6, 8'hC0, 1'b1);                // fixed instance ignores redir
    request(6);
    idle(3);

    // R3 all-zero mask -> cpu0
    cur_req = "R3";
    set_entry(7, 0, 1'b0);
    request(7);
    set_entry(8, 0, 1'b1);
    request(8);
    idle(3);

    // R4 wrap-around tie: default 6, minima at 1 and 3 -> cpu1
    cur_req = "R4";
    for (int c = 0; c < N; c++) set_hint(c, 1);
    set_hint(1, 0);
    set_hint(3, 0);
    set_entry(9, 8'h40, 1'b1);
    request(9);
    set_hint(7, 0);                           // now 7 reached first
    request(9);
    for (int c = 0; c < N; c++) set_hint(c, 2);
    request(9);                               // all equal -> default 6
    idle(3);

    // R8 same-edge writes + requests, randomized
    cur_req = "R8";
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      hint_we = 1'($urandom);  hint_cpu = CW'($urandom); hint_val = 2'($urandom);
      entry_we = 1'(($urandom % 4) == 0); entry_src = SW'($urandom);
      entry_mask = ($urandom % 5 == 0) ? '0 : N'($urandom); entry_redir = 1'($urandom);
      req_valid = 1'($urandom); req_src = SW'($urandom);
    end
    idle(4);
    cur_req = "R1";
    idle(2);
    finish_run();
  end
endmodule